// File: doc/BRIEF.md
# Synchronous Rectifier Gate Sequencer

This block drives the two gate enables of a push-pull secondary-side synchronous rectifier. Two external comparators signal the primary transformer transitions as one-cycle strobes, one for each polarity. In normal running these strobes alternate, and the sequencer hands conduction back and forth between the two rectifier switches. A negative strobe enables `gate_e` and a positive strobe enables `gate_f`. Two gates are never enabled together.

The block has three protections. First, a repeated strobe of the same polarity blocks both gates until a strobe of the opposite polarity arrives. This also covers a lone strobe from one comparator, such as a marginal swing at power-up. Second, each gate has its own reverse-current flag that turns off only that gate. The flag is ignored for `BLANK_CYC` clock edges after the gate turns on, so switching noise cannot cut the gate short. Third, a cycle-count watchdog blocks both gates when no strobe arrives within `TMO_CYC` cycles. It should be set near one primary switching period, and holding `tmr_en` low disables it.

The controller is a five-state machine:
- **ST_READY**: the reset state; it accepts either polarity.
- **ST_F_ON**: the last accepted strobe was positive; `gate_f` may be enabled.
- **ST_E_ON**: the last accepted strobe was negative; `gate_e` may be enabled.
- **ST_BLOCK_N**: both gates are blocked until a negative strobe.
- **ST_BLOCK_P**: both gates are blocked until a positive strobe.

The transitions are:
- ST_READY goes to ST_F_ON on a positive strobe and to ST_E_ON on a negative strobe.
- ST_F_ON goes to ST_E_ON on a negative strobe, and to ST_BLOCK_N on a positive strobe or on a timeout.
- ST_E_ON goes to ST_F_ON on a positive strobe, and to ST_BLOCK_P on a negative strobe or on a timeout.
- ST_BLOCK_N goes to ST_E_ON on a negative strobe.
- ST_BLOCK_P goes to ST_F_ON on a positive strobe.
- Every other condition leaves the state unchanged.

The gate outputs are registered. Each one changes at the same clock edge as the state that selects it.

Top module: `sr_gate_seq`

## Requirements
- R1: While reset is active, and in the first cycle after it, both gates are low. The first strobe after reset is accepted whatever its polarity.
- R2: A positive strobe arriving when the last accepted strobe was negative (or when no strobe has been accepted yet) sets `gate_f` high and `gate_e` low after the next clock edge.
- R3: A negative strobe arriving when the last accepted strobe was positive (or when no strobe has been accepted yet) sets `gate_e` high and `gate_f` low after the next clock edge.
- R4: A second positive strobe in a row drives both gates low. Further positive strobes keep them low, and the next negative strobe enables `gate_e`.
- R5: A second negative strobe in a row drives both gates low. Further negative strobes keep them low, and the next positive strobe enables `gate_f`.
- R6: A cycle in which both strobes are high is ignored. It does not change the state and does not restart the timeout.
- R7: When `rev_f` is high at a clock edge outside the blanking window of `gate_f`, `gate_f` goes low after that edge. It stays low until the next positive strobe that enables it, and `gate_e` is not affected.
- R8: When `rev_e` is high at a clock edge outside the blanking window of `gate_e`, `gate_e` goes low after that edge. It stays low until the next negative strobe that enables it, and `gate_f` is not affected.
- R9: The reverse-current flag of a gate is ignored at the `BLANK_CYC` clock edges that follow the edge at which that gate turned on. It is honored from the `BLANK_CYC`+1-th edge onward.
- R10: With `tmr_en` high, when `TMO_CYC` clock edges pass after the last accepted strobe without a new one, both gates go low at the `TMO_CYC`-th edge. A following strobe of the same polarity keeps them low; a strobe of the opposite polarity resumes alternation.
- R11: With `tmr_en` low, an enabled gate stays enabled however long no strobe arrives.
- R12: `gate_e` and `gate_f` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sync_pos | input | 1 | One-cycle strobe from the positive-polarity comparator |
| sync_neg | input | 1 | One-cycle strobe from the negative-polarity comparator |
| rev_e | input | 1 | Reverse-current flag for the switch driven by `gate_e` |
| rev_f | input | 1 | Reverse-current flag for the switch driven by `gate_f` |
| tmr_en | input | 1 | High enables the missing-strobe timeout |
| gate_e | output | 1 | Gate enable, turned on by negative strobes |
| gate_f | output | 1 | Gate enable, turned on by positive strobes |

## Verification
The assertions check these properties on every cycle:
- Both gates are never high together.
- A strobe of either polarity always clears the gate it does not enable.
- A cycle with both strobes high leaves the state unchanged.
- A reverse-current flag outside blanking removes its gate at the next edge.
- A gate inside blanking survives when no strobe or timeout intervenes.
- A timeout leaves both gates low.

Only the scenarios in the bench can show the following:
- The exact length of the blanking window and of the timeout, counted in edges.
- That a lockout persists across repeated same-polarity strobes and clears on the opposite polarity.
- That alternation resumes correctly after a timeout.
- That disabling the timer keeps a gate on through a long quiet interval.

// File: rtl/sr_seq_pkg.sv
`timescale 1ns/1ps
package sr_seq_pkg;

    typedef enum logic [2:0] {
        ST_READY   = 3'd0,
        ST_F_ON    = 3'd1,
        ST_E_ON    = 3'd2,
        ST_BLOCK_N = 3'd3,
        ST_BLOCK_P = 3'd4
    } seq_state_t;

    localparam int unsigned N_GATES = 2;
    localparam int unsigned IDX_E   = 0;
    localparam int unsigned IDX_F   = 1;

endpackage

// File: rtl/sr_blank_window.sv
`timescale 1ns/1ps
module sr_blank_window #(
    parameter int unsigned BLANK_CYC = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic blanked
);
    localparam int unsigned BW = $clog2(BLANK_CYC + 1);

    logic [BW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= BW'(BLANK_CYC);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign blanked = (cnt_q != '0);

    // R9: a freshly started window is open at the following edge
    a_r9_window_opens: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> blanked);

endmodule

// File: rtl/sr_sync_watchdog.sv
`timescale 1ns/1ps
module sr_sync_watchdog #(
    parameter int unsigned TMO_CYC = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic restart,
    output logic fire
);
    localparam int unsigned CW = $clog2(TMO_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(TMO_CYC - 1);
    localparam logic [CW-1:0] SAT  = CW'(TMO_CYC);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en || restart) begin
            cnt_q <= '0;
        end else if (cnt_q != SAT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign fire = en && !restart && (cnt_q == LAST);

    // R11: a disabled timer cannot expire in the cycle that follows
    a_r11_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !fire);

endmodule

// File: rtl/sr_gate_seq.sv
`timescale 1ns/1ps
module sr_gate_seq
    import sr_seq_pkg::*;
#(
    parameter int unsigned BLANK_CYC = 13,
    parameter int unsigned TMO_CYC   = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_pos,
    input  logic sync_neg,
    input  logic rev_e,
    input  logic rev_f,
    input  logic tmr_en,
    output logic gate_e,
    output logic gate_f
);
    seq_state_t state_q, state_d;

    logic pos_ev, neg_ev, tmo_fire;
    logic [N_GATES-1:0] turn_on, blanked, rev_in, gate_q;

    assign pos_ev = sync_pos && !sync_neg;
    assign neg_ev = sync_neg && !sync_pos;
    assign rev_in[IDX_E] = rev_e;
    assign rev_in[IDX_F] = rev_f;

    sr_sync_watchdog #(.TMO_CYC(TMO_CYC)) u_wdog (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (tmr_en),
        .restart (pos_ev || neg_ev),
        .fire    (tmo_fire)
    );

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_READY: begin
                if (pos_ev)      state_d = ST_F_ON;
                else if (neg_ev) state_d = ST_E_ON;
            end
            ST_F_ON: begin
                if (neg_ev)                   state_d = ST_E_ON;
                else if (pos_ev || tmo_fire)  state_d = ST_BLOCK_N;
            end
            ST_E_ON: begin
                if (pos_ev)                   state_d = ST_F_ON;
                else if (neg_ev || tmo_fire)  state_d = ST_BLOCK_P;
            end
            ST_BLOCK_N: begin
                if (neg_ev) state_d = ST_E_ON;
            end
            ST_BLOCK_P: begin
                if (pos_ev) state_d = ST_F_ON;
            end
            default: state_d = ST_READY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_READY;
        else        state_q <= state_d;
    end

    assign turn_on[IDX_E] = (state_d == ST_E_ON) && (state_q != ST_E_ON);
    assign turn_on[IDX_F] = (state_d == ST_F_ON) && (state_q != ST_F_ON);

    for (genvar g = 0; g < N_GATES; g++) begin : g_blank
        sr_blank_window #(.BLANK_CYC(BLANK_CYC)) u_blank (
            .clk     (clk),
            .rst_n   (rst_n),
            .start   (turn_on[g]),
            .blanked (blanked[g])
        );
    end

    // gate outputs, registered alongside the state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_q <= '0;
        end else begin
            gate_q[IDX_E] <= (state_d == ST_E_ON) &&
                (turn_on[IDX_E] || (gate_q[IDX_E] && !(rev_in[IDX_E] && !blanked[IDX_E])));
            gate_q[IDX_F] <= (state_d == ST_F_ON) &&
                (turn_on[IDX_F] || (gate_q[IDX_F] && !(rev_in[IDX_F] && !blanked[IDX_F])));
        end
    end

    assign gate_e = gate_q[IDX_E];
    assign gate_f = gate_q[IDX_F];

    a_r12_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_e && gate_f));

    a_r2_pos_drops_e: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_pos && !sync_neg) |=> !gate_e);

    a_r3_neg_drops_f: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_neg && !sync_pos) |=> !gate_f);

    a_r6_both_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_pos && sync_neg && !tmo_fire) |=> $stable(state_q));

    a_r7_rev_f_off: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_f && rev_f && !blanked[IDX_F]) |=> !gate_f);

    a_r8_rev_e_off: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_e && rev_e && !blanked[IDX_E]) |=> !gate_e);

    a_r9_blank_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_e && blanked[IDX_E] && !sync_pos && !sync_neg && !tmo_fire) |=> gate_e);

    a_r10_timeout_off: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_fire |=> (!gate_e && !gate_f));

endmodule

// File: tb/sim_sr_gate_seq.sv
`timescale 1ns/1ps
module sim_sr_gate_seq;

    localparam int unsigned BLANK = 4;
    localparam int unsigned TMO   = 30;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sync_pos = 1'b0, sync_neg = 1'b0, rev_e = 1'b0, rev_f = 1'b0;
    logic tmr_en = 1'b1;
    logic gate_e, gate_f;

    int n_chk = 0;
    int n_err = 0;

    typedef struct {
        bit    care;
        logic  e;
        logic  f;
        string tag;
    } exp_t;

    exp_t q[$];

    always #10 clk = ~clk;

    sr_gate_seq #(.BLANK_CYC(BLANK), .TMO_CYC(TMO)) u0 (
        .clk(clk), .rst_n(rst_n), .sync_pos(sync_pos), .sync_neg(sync_neg),
        .rev_e(rev_e), .rev_f(rev_f), .tmr_en(tmr_en),
        .gate_e(gate_e), .gate_f(gate_f)
    );

    // monitor: compares each expectation 5 ns after the edge it belongs to
    initial begin
        exp_t x;
        forever begin
            @(posedge clk);
            #5;
            if (q.size() > 0) begin
                x = q.pop_front();
                if (x.care) begin
                    n_chk++;
                    if (gate_e !== x.e || gate_f !== x.f) begin
                        n_err++;
                        $display("FAIL %s: gate_e,gate_f=%b%b expected %b%b",
                                 x.tag, gate_e, gate_f, x.e, x.f);
                    end
                end
                n_chk++;
                if (gate_e === 1'b1 && gate_f === 1'b1) begin
                    n_err++;
                    $display("FAIL R12: gate_e,gate_f=11 expected not both high");
                end
            end
        end
    end

    // driver: applies one cycle of inputs and queues the result expected after the next edge
    task automatic cyc(input logic p, input logic n, input logic re, input logic rf,
                       input bit care, input logic ee, input logic ef, input string tag);
        exp_t x;
        @(negedge clk);
        sync_pos = p; sync_neg = n; rev_e = re; rev_f = rf;
        x.care = care; x.e = ee; x.f = ef; x.tag = tag;
        q.push_back(x);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        sync_pos = 1'b0; sync_neg = 1'b0; rev_e = 1'b0; rev_f = 1'b0;
        @(posedge clk);
        #5;
        n_chk++;
        if (gate_e !== 1'b0 || gate_f !== 1'b0) begin
            n_err++;
            $display("FAIL R1: gate_e,gate_f=%b%b expected 00", gate_e, gate_f);
        end
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(20 * 200000);
        n_err++;
        $display("FAIL watchdog: run hung, actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        do_reset();
        cyc(0,0,0,0, 1, 0,0, "R1");          // idle after reset
        cyc(1,0,0,0, 1, 0,1, "R2");          // first strobe positive accepted
        cyc(0,1,0,0, 1, 1,0, "R3");          // alternation to gate_e
        cyc(1,0,0,0, 1, 0,1, "R2");          // gate_f turns on
        // R9 blanking of rev_f, then R7 turn-off
        for (int i = 0; i < int'(BLANK); i++) cyc(0,0,0,1, 1, 0,1, "R9");
        cyc(0,0,0,1, 1, 0,0, "R7");
        cyc(0,0,0,0, 1, 0,0, "R7");          // stays off once flag drops
        cyc(0,1,0,0, 1, 1,0, "R3");
        for (int i = 0; i < int'(BLANK); i++) cyc(0,0,1,0, 1, 1,0, "R9");
        cyc(0,0,1,0, 1, 0,0, "R8");
        cyc(0,0,0,0, 1, 0,0, "R8");
        cyc(1,0,0,0, 1, 0,1, "R2");
        cyc(0,1,0,0, 1, 1,0, "R3");
        // R5 double negative
        cyc(0,1,0,0, 1, 0,0, "R5");
        cyc(0,1,0,0, 1, 0,0, "R5");
        cyc(1,0,0,0, 1, 0,1, "R5");
        // R4 double positive
        cyc(1,0,0,0, 1, 0,0, "R4");
        cyc(1,0,0,0, 1, 0,0, "R4");
        cyc(0,1,0,0, 1, 1,0, "R4");
        // R6 simultaneous strobes ignored
        cyc(1,1,0,0, 1, 1,0, "R6");
        cyc(1,0,0,0, 1, 0,1, "R6");
        // R10 timeout after TMO edges
        for (int i = 1; i < int'(TMO); i++) cyc(0,0,0,0, 1, 0,1, "R10");
        cyc(0,0,0,0, 1, 0,0, "R10");
        cyc(1,0,0,0, 1, 0,0, "R10");         // same polarity stays blocked
        cyc(0,1,0,0, 1, 1,0, "R10");         // opposite polarity resumes
        // R11 timer disabled
        tmr_en = 1'b0;
        cyc(1,0,0,0, 1, 0,1, "R11");
        for (int i = 0; i < int'(TMO) + 10; i++) cyc(0,0,0,0, 0, 0,0, "R11");
        cyc(0,0,0,0, 1, 0,1, "R11");
        tmr_en = 1'b1;
        // R1 reset mid-run, then negative accepted first
        do_reset();
        cyc(0,1,0,0, 1, 1,0, "R1");
        cyc(0,0,0,0, 1, 1,0, "R1");
        @(negedge clk);
        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule